// File: doc/BRIEF.md
# DMA Channel Counter and Termination Unit

This block keeps the address and word-count state of four DMA channels. Each channel has a 16-bit base address, a base count, a current address and a current count. A host loads these one byte at a time through a narrow write port. An internal byte-order toggle decides whether each byte goes to the low half or the high half. Every load writes both the base copy and the current copy.

A transfer sequencer outside the block strobes `step` for the channel that is being served. Each strobe moves the channel's current address by one, up or down as its mode bit selects, and decrements its current count. A strobe that finds the count at zero is the terminal count. The terminal count, or an external low on the shared open-drain end-of-process line while a service is active, ends that channel's service.

When a service ends, the channel's done bit is set. A channel with auto-reload enabled copies its base registers back into its current registers and stays unmasked. Any other channel is masked. A terminal count drives the end-of-process line low for one cycle, except on channel 0 while memory-to-memory mode is on.

Top module: `dma_count_term`

## Requirements
- R1: After reset all mask bits are 1 (`mask_o`=4'hF), all done bits are 0, `eop_drive_o` is 0, and the byte toggle selects the low byte.
- R2: A write to channel register address 2c (address) or 2c+1 (count) loads the byte into bits [7:0] when the toggle is low and into bits [15:8] when it is high. Both the base and the current copy are loaded, and the toggle flips after each such write. A write to address 11 returns the toggle to low.
- R3: A `step` strobe with `svc_act` high decrements the current count of channel `svc_ch` by one. It increments the current address when that channel's direction bit is 0 and decrements it when the bit is 1.
- R4: A step taken when the current count is 0 is a terminal count. The count wraps to 16'hFFFF, and `eop_drive_o` is high for exactly the one cycle after that step.
- R5: With memory-to-memory mode on (address 10, data bit 0), a terminal count on channel 0 does not drive the end-of-process line. A terminal count on channel 1 does drive it.
- R6: `eop_in_n` low while `svc_act` is high, and while the block is not itself driving the line, ends the service of channel `svc_ch` exactly as a terminal count would. The current address of that channel is left unchanged.
- R7: When a channel with auto-reload set ends its service, its current address and current count take the base values on that edge, and its mask bit stays 0.
- R8: When a channel without auto-reload ends its service, its mask bit becomes 1.
- R9: The end of a service sets that channel's bit in `tc_o`. A `stat_rd` pulse clears all `tc_o` bits, and a bit being set in the same cycle as `stat_rd` ends up set.
- R10: Address 8 writes a channel's mode: data[1:0] is the channel, data[2] is auto-reload and data[3] is direction. Address 9 writes one mask bit: data[1:0] is the channel and data[2] is the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (channel registers 0..7, commands 8..11) |
| wr_data | input | 8 | Write data byte |
| stat_rd | input | 1 | Status read pulse; clears the done bits |
| svc_act | input | 1 | A channel service is in progress |
| svc_ch | input | 2 | Channel being served, also selects `addr_o`/`cnt_o` |
| step | input | 1 | One transfer completed on `svc_ch` |
| eop_in_n | input | 1 | Sensed level of the open-drain end-of-process line |
| eop_drive_o | output | 1 | Pull the end-of-process line low |
| addr_o | output | 16 | Current address of channel `svc_ch` |
| cnt_o | output | 16 | Current count of channel `svc_ch` |
| mask_o | output | 4 | Per-channel mask bits |
| tc_o | output | 4 | Per-channel done bits |

## Verification
The hardest case to reach is two events landing on the same edge. In one, an auto-reload channel ends its service in the very cycle that the status read clears the done bits. In the other, an external end-of-process arrives while a channel is halfway through its count. The stimulus first steps a channel down to exactly zero. It then issues the final step together with `stat_rd`, or pulls the shared line low after a partial run. After each of these, the done, mask, address and count values are read back through `svc_ch`.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
    // command-space register selectors (wr_addr[1:0] when wr_addr[3] is set)
    localparam logic [1:0] CMD_MODE  = 2'd0;
    localparam logic [1:0] CMD_MASK  = 2'd1;
    localparam logic [1:0] CMD_CTRL  = 2'd2;
    localparam logic [1:0] CMD_FFCLR = 2'd3;
    localparam int         BYTE_W    = 8;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_cnt_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic          ld_cnt,
    input  logic [7:0]    ld_byte,
    input  logic          step,
    input  logic          dec,
    input  logic          reload,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] cnt_o,
    output logic          tc_o
);
    typedef struct packed {
        logic [AW-1:0] badr;
        logic [AW-1:0] bcnt;
        logic [AW-1:0] cadr;
        logic [AW-1:0] ccnt;
    } chan_t;

    chan_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (reload) begin
            s_d.cadr = s_q.badr;
            s_d.ccnt = s_q.bcnt;
        end else if (ld_lo) begin
            if (ld_cnt) begin
                s_d.bcnt[BYTE_W-1:0] = ld_byte;
                s_d.ccnt[BYTE_W-1:0] = ld_byte;
            end else begin
                s_d.badr[BYTE_W-1:0] = ld_byte;
                s_d.cadr[BYTE_W-1:0] = ld_byte;
            end
        end else if (ld_hi) begin
            if (ld_cnt) begin
                s_d.bcnt[AW-1:BYTE_W] = ld_byte[AW-BYTE_W-1:0];
                s_d.ccnt[AW-1:BYTE_W] = ld_byte[AW-BYTE_W-1:0];
            end else begin
                s_d.badr[AW-1:BYTE_W] = ld_byte[AW-BYTE_W-1:0];
                s_d.cadr[AW-1:BYTE_W] = ld_byte[AW-BYTE_W-1:0];
            end
        end else if (step) begin
            s_d.cadr = dec ? s_q.cadr - 1'b1 : s_q.cadr + 1'b1;
            s_d.ccnt = s_q.ccnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign addr_o = s_q.cadr;
    assign cnt_o  = s_q.ccnt;
    assign tc_o   = step && (s_q.ccnt == '0);

    // R3: a plain step lowers the count by one
    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        (step && !reload && !ld_lo && !ld_hi) |=> cnt_o == AW'($past(cnt_o) - 1'b1));
    // R4: terminal count without reload wraps to all ones
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (tc_o && !reload) |=> cnt_o == '1);
    // R7: reload restores the base address
    a_r7_reload_addr: assert property (@(posedge clk) disable iff (rst)
        reload |=> addr_o == $past(s_q.badr));
endmodule

// File: rtl/dma_count_term.sv
module dma_count_term
    import dma_cnt_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [$clog2(NCH)+1:0]  wr_addr,
    input  logic [7:0]              wr_data,
    input  logic                    stat_rd,
    input  logic                    svc_act,
    input  logic [$clog2(NCH)-1:0]  svc_ch,
    input  logic                    step,
    input  logic                    eop_in_n,
    output logic                    eop_drive_o,
    output logic [AW-1:0]           addr_o,
    output logic [AW-1:0]           cnt_o,
    output logic [NCH-1:0]          mask_o,
    output logic [NCH-1:0]          tc_o
);
    localparam int CW  = $clog2(NCH);
    localparam int RAW = CW + 2;

    typedef struct packed {
        logic           ff;
        logic           m2m;
        logic           eop;
        logic [NCH-1:0] autoi;
        logic [NCH-1:0] dirdn;
        logic [NCH-1:0] mask;
        logic [NCH-1:0] tc;
    } ctl_t;

    ctl_t c_d, c_q;

    logic           chan_wr, cmd_wr, ext_eop;
    logic [CW-1:0]  wch, dch;
    logic [NCH-1:0] tc_hit, term, reload, ld_lo, ld_hi;
    logic [AW-1:0]  ch_addr [NCH];
    logic [AW-1:0]  ch_cnt  [NCH];

    assign chan_wr = wr_en && !wr_addr[RAW-1];
    assign cmd_wr  = wr_en &&  wr_addr[RAW-1];
    assign wch     = wr_addr[CW:1];
    assign dch     = wr_data[CW-1:0];
    assign ext_eop = svc_act && !eop_in_n && !c_q.eop;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ld_lo[g]  = chan_wr && (wch == CW'(g)) && !c_q.ff;
        assign ld_hi[g]  = chan_wr && (wch == CW'(g)) &&  c_q.ff;
        assign term[g]   = tc_hit[g] || (ext_eop && svc_ch == CW'(g));
        assign reload[g] = term[g] && c_q.autoi[g];

        dma_chan_regs #(.AW(AW)) u_regs (
            .clk    (clk),
            .rst    (rst),
            .ld_lo  (ld_lo[g]),
            .ld_hi  (ld_hi[g]),
            .ld_cnt (wr_addr[0]),
            .ld_byte(wr_data),
            .step   (step && svc_act && svc_ch == CW'(g)),
            .dec    (c_q.dirdn[g]),
            .reload (reload[g]),
            .addr_o (ch_addr[g]),
            .cnt_o  (ch_cnt[g]),
            .tc_o   (tc_hit[g])
        );

        // R8: end of service without reload masks the channel
        a_r8_mask_on_end: assert property (@(posedge clk) disable iff (rst)
            (term[g] && !c_q.autoi[g]) |=> mask_o[g]);
        // R9: end of service always leaves the done bit set
        a_r9_done_set: assert property (@(posedge clk) disable iff (rst)
            term[g] |=> tc_o[g]);
        // R7: a reloading channel keeps its mask unless software writes it
        a_r7_mask_kept: assert property (@(posedge clk) disable iff (rst)
            (reload[g] && !mask_o[g] && !(cmd_wr && wr_addr[1:0] == CMD_MASK))
            |=> !mask_o[g]);
    end

    always_comb begin
        c_d     = c_q;
        c_d.eop = 1'b0;
        if (chan_wr) c_d.ff = !c_q.ff;
        if (cmd_wr) begin
            unique case (wr_addr[1:0])
                CMD_MODE: begin
                    c_d.autoi[dch] = wr_data[CW];
                    c_d.dirdn[dch] = wr_data[CW+1];
                end
                CMD_MASK:  c_d.mask[dch] = wr_data[CW];
                CMD_CTRL:  c_d.m2m = wr_data[0];
                CMD_FFCLR: c_d.ff = 1'b0;
                default: ;
            endcase
        end
        if (stat_rd) c_d.tc = '0;
        for (int c = 0; c < NCH; c++) begin
            if (term[c]) begin
                c_d.tc[c] = 1'b1;
                if (!c_q.autoi[c]) c_d.mask[c] = 1'b1;
            end
            if (tc_hit[c] && !(c == 0 && c_q.m2m)) c_d.eop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q      <= '0;
            c_q.mask <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign eop_drive_o = c_q.eop;
    assign mask_o      = c_q.mask;
    assign tc_o        = c_q.tc;
    assign addr_o      = ch_addr[svc_ch];
    assign cnt_o       = ch_cnt[svc_ch];

    // R4: only one channel can reach terminal count per cycle
    a_r4_single_tc: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tc_hit));
    // R5: channel 0 stays silent in memory-to-memory mode
    a_r5_m2m_quiet: assert property (@(posedge clk) disable iff (rst)
        (c_q.m2m && tc_hit[0]) |=> !eop_drive_o);
    // R4: every non-suppressed terminal count drives the line next cycle
    a_r4_eop_pulse: assert property (@(posedge clk) disable iff (rst)
        (|tc_hit[NCH-1:1]) |=> eop_drive_o);
endmodule

// File: tb/sim_dma_count_term.sv
module sim_dma_count_term;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        stat_rd = 1'b0;
    logic        svc_act = 1'b0;
    logic [1:0]  svc_ch = '0;
    logic        step = 1'b0;
    logic        ext_n = 1'b1;
    logic        eop_in_n;
    logic        eop_drive_o;
    logic [15:0] addr_o, cnt_o;
    logic [3:0]  mask_o, tc_o;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        int          sel;
        logic [31:0] exp;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    assign eop_in_n = ext_n & ~eop_drive_o;

    dma_count_term u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stat_rd(stat_rd), .svc_act(svc_act), .svc_ch(svc_ch), .step(step),
        .eop_in_n(eop_in_n), .eop_drive_o(eop_drive_o), .addr_o(addr_o),
        .cnt_o(cnt_o), .mask_o(mask_o), .tc_o(tc_o)
    );

    // monitor: pops expected items and compares against the live outputs
    initial begin
        forever begin
            item_t it;
            logic [31:0] got;
            wait (sb.size() != 0);
            it = sb.pop_front();
            case (it.sel)
                0: got = {16'h0, addr_o};
                1: got = {16'h0, cnt_o};
                2: got = {28'h0, mask_o};
                3: got = {28'h0, tc_o};
                default: got = {31'h0, eop_drive_o};
            endcase
            nvec++;
            if (got !== it.exp) begin
                nfail++;
                $display("FAIL %s sel=%0d got=%h exp=%h", it.req, it.sel, got, it.exp);
            end
        end
    end

    task automatic expect_out(input logic [1:0] ch, input int sel,
                              input logic [31:0] exp, input string req);
        item_t it;
        svc_ch = ch;
        #1;
        it.req = req; it.sel = sel; it.exp = exp;
        sb.push_back(it);
        #0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic load16(input int ch, input bit is_cnt, input logic [15:0] v);
        wr(4'(2 * ch + int'(is_cnt)), v[7:0]);
        wr(4'(2 * ch + int'(is_cnt)), v[15:8]);
    endtask

    task automatic do_step(input logic [1:0] ch, input bit rd);
        @(negedge clk); svc_act = 1'b1; svc_ch = ch; step = 1'b1; stat_rd = rd;
        @(negedge clk); step = 1'b0; stat_rd = 1'b0; svc_act = 1'b0;
    endtask

    task automatic status_read();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic ext_end(input logic [1:0] ch);
        @(negedge clk); svc_act = 1'b1; svc_ch = ch; ext_n = 1'b0;
        @(negedge clk); ext_n = 1'b1; svc_act = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_out(0, 2, 32'hF, "R1 mask");
        expect_out(0, 3, 32'h0, "R1 tc");
        expect_out(0, 4, 32'h0, "R1 eop");

        // R2 byte loads, R10 mode and mask writes
        load16(1, 0, 16'h1234);
        load16(1, 1, 16'h0002);
        expect_out(1, 0, 32'h1234, "R2 addr load");
        expect_out(1, 1, 32'h0002, "R2 count load");
        wr(4'd8, 8'h01);
        wr(4'd9, 8'h01);
        expect_out(1, 2, 32'hD, "R10 mask clear ch1");

        // R3 stepping upward
        do_step(1, 0);
        expect_out(1, 0, 32'h1235, "R3 addr up");
        expect_out(1, 1, 32'h0001, "R3 count down");
        do_step(1, 0);
        do_step(1, 0);
        // R4 terminal count, R8 mask, R9 done
        expect_out(1, 0, 32'h1237, "R4 addr after tc");
        expect_out(1, 1, 32'hFFFF, "R4 count wrap");
        expect_out(1, 4, 32'h1, "R4 eop pulse");
        expect_out(1, 3, 32'h2, "R9 done ch1");
        expect_out(1, 2, 32'hF, "R8 mask set ch1");
        @(negedge clk);
        expect_out(1, 4, 32'h0, "R4 eop one cycle");
        status_read();
        expect_out(1, 3, 32'h0, "R9 status clear");

        // R7 auto-reload with downward direction (R10 mode bits)
        load16(2, 0, 16'h0100);
        load16(2, 1, 16'h0001);
        wr(4'd8, 8'h0E);
        wr(4'd9, 8'h02);
        do_step(2, 0);
        expect_out(2, 0, 32'h00FF, "R3 addr down");
        expect_out(2, 1, 32'h0000, "R3 count to zero");
        do_step(2, 0);
        expect_out(2, 0, 32'h0100, "R7 addr reload");
        expect_out(2, 1, 32'h0001, "R7 count reload");
        expect_out(2, 2, 32'hB, "R7 mask kept clear");
        expect_out(2, 3, 32'h4, "R9 done ch2");
        expect_out(2, 4, 32'h1, "R4 eop ch2");

        // R2 toggle reset
        wr(4'd6, 8'h55);
        wr(4'd11, 8'h00);
        wr(4'd6, 8'h66);
        expect_out(3, 0, 32'h0066, "R2 toggle cleared");
        wr(4'd6, 8'h77);
        expect_out(3, 0, 32'h7766, "R2 high byte");

        // R5 memory-to-memory suppression
        wr(4'd10, 8'h01);
        load16(0, 1, 16'h0000);
        wr(4'd9, 8'h00);
        expect_out(0, 2, 32'hA, "R10 mask clear ch0");
        do_step(0, 0);
        expect_out(0, 4, 32'h0, "R5 ch0 silent");
        expect_out(0, 3, 32'h5, "R9 done ch0");
        expect_out(0, 2, 32'hB, "R8 mask set ch0");
        load16(1, 1, 16'h0000);
        do_step(1, 0);
        expect_out(1, 4, 32'h1, "R5 ch1 pulses");
        expect_out(1, 3, 32'h7, "R9 done ch1 m2m");

        // R6 external end of process
        status_read();
        wr(4'd9, 8'h03);
        expect_out(3, 2, 32'h3, "R10 mask clear ch3");
        ext_end(3);
        expect_out(3, 3, 32'h8, "R6 done ch3");
        expect_out(3, 2, 32'hB, "R6 mask set ch3");
        expect_out(3, 0, 32'h7766, "R6 addr unchanged");
        expect_out(3, 4, 32'h0, "R6 no self drive");
        do_step(2, 0);
        ext_end(2);
        expect_out(2, 0, 32'h0100, "R6 ext reload addr");
        expect_out(2, 1, 32'h0001, "R6 ext reload count");
        expect_out(2, 3, 32'hC, "R6 done ch2");

        // R9 set wins over a concurrent status read
        do_step(2, 0);
        do_step(2, 1);
        expect_out(2, 3, 32'h4, "R9 set beats clear");
        expect_out(2, 1, 32'h0001, "R7 reload again");

        #2;
        wait (sb.size() == 0);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule